// File: doc/BRIEF.md
# Unsigned Multiply Unit with Y Register

This block carries out a 32-bit unsigned multiply for a load/store processor core. The first operand always comes from a general register. The second comes either from a general register or from a 13-bit constant carried in the instruction word. A flag chooses between the two. The unit forms the full 64-bit product over several cycles, shifting and adding one digit of the multiplier per cycle.

The low 32 bits of the product are returned for writeback into the destination general register. The high 32 bits land in a dedicated Y state register. Software may also write the Y register directly, and its current value is always visible on a read port.

The pipeline starts an operation with a one-cycle start pulse. It stalls while busy is high and picks up the result when a one-cycle done pulse appears.

Top module: `umul_y_unit`

## Requirements
- R1: While reset is asserted and after its release, `busy_o` and `done_o` are 0 and `y_o` reads 0.
- R2: When `done_o` is 1, `rd_data_o` holds the least significant 32 bits of the unsigned 64-bit product of the latched operands.
- R3: On the clock edge that raises `done_o`, the Y register takes the most significant 32 bits of that product. `y_o` shows them while `done_o` is high.
- R4: When `use_imm_i` is 1 at start, the second operand is `imm_i` sign-extended from bit 12 to 32 bits, and `rs2_i` is not used. When `use_imm_i` is 0, the second operand is `rs2_i`.
- R5: A start is accepted on an edge where `busy_o` is 0. `busy_o` rises on that edge. Exactly STEPS = DATA_W/DIGIT_W edges later, `busy_o` falls and `done_o` rises on the same edge. `busy_o` and `done_o` are never 1 together.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: A start seen while `busy_o` is 1 is ignored. It neither changes the operands being multiplied nor the completion time.
- R8: On an edge where no product is completing and `y_wr_en_i` is 1, the Y register loads `y_wr_data_i`. This also applies while a multiply is in progress.
- R9: If `y_wr_en_i` is 1 on the edge that raises `done_o`, the product's high word is written to Y and the direct write data is discarded.
- R10: With no direct write and no completing product, the Y register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| imm_i | input | 13 | Inline constant from the instruction |
| use_imm_i | input | 1 | 1 selects the sign-extended constant as second operand |
| y_wr_en_i | input | 1 | Direct write enable for the Y register |
| y_wr_data_i | input | 32 | Direct write data for the Y register |
| busy_o | output | 1 | Multiply in progress; pipeline must stall |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 32 | Low product word for the destination register, valid with done_o |
| y_o | output | 32 | Current Y register contents |

## Verification
The assertions assume a few things about the inputs. Reset is held for at least one edge before operation. Operands matter only on the edge where a start is accepted. A direct Y write is a single-cycle request like any register write.

The stimulus keeps start and the operands stable between falling edges. It drives direct Y writes alone, during a multiply, and across the completion edge. It also holds start high through whole busy windows with different operands, so that any start that leaked through would show as a wrong product or a shifted done pulse.

// File: rtl/umul_pkg.sv
package umul_pkg;

   typedef enum logic {
      SRC_REG = 1'b0,
      SRC_IMM = 1'b1
   } umul_src_e;

endpackage

// File: rtl/umul_opsel.sv
module umul_opsel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 13
) (
   input  logic [DATA_W-1:0] rs2_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   output logic [DATA_W-1:0] opb_o
);
   import umul_pkg::*;

   localparam int EXT_W = DATA_W - IMM_W;

   umul_src_e           src;
   logic [DATA_W-1:0]   imm_ext;

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("umul_opsel: IMM_W must not exceed DATA_W");
      end
      if (EXT_W == 0) begin : g_no_ext
         assign imm_ext = imm_i;
      end else begin : g_ext
         assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      end
   endgenerate

   assign src   = use_imm_i ? SRC_IMM : SRC_REG;
   assign opb_o = (src == SRC_IMM) ? imm_ext : rs2_i;

endmodule

// File: rtl/umul_engine.sv
module umul_engine #(
   parameter int DATA_W  = 32,
   parameter int DIGIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fin_o,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_next_o
);
   localparam int STEPS  = DATA_W / DIGIT_W;
   localparam int CNT_W  = $clog2(STEPS + 1);
   localparam int PART_W = DATA_W + DIGIT_W;

   logic [DATA_W-1:0] hi_q, lo_q, mcand_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q, done_q;
   logic [PART_W-1:0] part, sum;
   logic [DATA_W-1:0] hi_nx, lo_nx;
   logic              fin;

   generate
      if (DIGIT_W < 1 || DIGIT_W > DATA_W) begin : g_bad_digit
         $error("umul_engine: DIGIT_W out of range");
      end
      if ((DATA_W % DIGIT_W) != 0) begin : g_bad_div
         $error("umul_engine: DIGIT_W must divide DATA_W");
      end
      if (DIGIT_W == 1) begin : g_radix2
         assign part = lo_q[0] ? {1'b0, mcand_q} : '0;
      end else begin : g_radixn
         assign part = PART_W'(mcand_q) * PART_W'(lo_q[DIGIT_W-1:0]);
      end
      if (DIGIT_W == DATA_W) begin : g_one_step
         assign lo_nx = sum[DIGIT_W-1:0];
      end else begin : g_multi_step
         assign lo_nx = {sum[DIGIT_W-1:0], lo_q[DATA_W-1:DIGIT_W]};
      end
   endgenerate

   assign sum   = PART_W'(hi_q) + part;
   assign hi_nx = sum[PART_W-1:DIGIT_W];
   assign fin   = busy_q && (cnt_q == CNT_W'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
         mcand_q <= '0;
      end else begin
         done_q <= fin;
         if (busy_q) begin
            hi_q  <= hi_nx;
            lo_q  <= lo_nx;
            cnt_q <= cnt_q + CNT_W'(1);
            if (fin) busy_q <= 1'b0;
         end else if (start_i) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= opb_i;
            mcand_q <= opa_i;
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign fin_o     = fin;
   assign lo_o      = lo_q;
   assign hi_next_o = hi_nx;

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q));
   p_busy_fall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin) |=> (busy_q && $stable(mcand_q)));

endmodule

// File: rtl/umul_yreg.sv
module umul_yreg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mul_we_i,
   input  logic [DATA_W-1:0] mul_hi_i,
   input  logic              sw_we_i,
   input  logic [DATA_W-1:0] sw_data_i,
   output logic [DATA_W-1:0] y_o
);
   logic [DATA_W-1:0] y_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_q <= '0;
      end else if (mul_we_i) begin
         y_q <= mul_hi_i;
      end else if (sw_we_i) begin
         y_q <= sw_data_i;
      end
   end

   assign y_o = y_q;

   p_mul_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_we_i && sw_we_i) |=> (y_q == $past(mul_hi_i)));
   p_sw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we_i && !mul_we_i) |=> (y_q == $past(sw_data_i)));
   p_y_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we_i && !mul_we_i) |=> $stable(y_q));

endmodule

// File: rtl/umul_y_unit.sv
module umul_y_unit #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 13,
   parameter int DIGIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] rs1_i,
   input  logic [DATA_W-1:0] rs2_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   input  logic              y_wr_en_i,
   input  logic [DATA_W-1:0] y_wr_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DATA_W-1:0] y_o
);
   logic [DATA_W-1:0] opb;
   logic              fin;
   logic [DATA_W-1:0] hi_next;

   umul_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opsel_i (
      .rs2_i     (rs2_i),
      .imm_i     (imm_i),
      .use_imm_i (use_imm_i),
      .opb_o     (opb)
   );

   umul_engine #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) engine_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .opa_i     (rs1_i),
      .opb_i     (opb),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .fin_o     (fin),
      .lo_o      (rd_data_o),
      .hi_next_o (hi_next)
   );

   umul_yreg #(.DATA_W(DATA_W)) yreg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mul_we_i  (fin),
      .mul_hi_i  (hi_next),
      .sw_we_i   (y_wr_en_i),
      .sw_data_i (y_wr_data_i),
      .y_o       (y_o)
   );

   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |-> (!busy_o && !done_o));

endmodule

// File: tb/umul_y_unit_tb.sv
module umul_y_unit_tb_top;
   localparam int DATA_W  = 32;
   localparam int IMM_W   = 13;
   localparam int DIGIT_W = 4;
   localparam int STEPS   = DATA_W / DIGIT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [DATA_W-1:0] rs1_i = '0, rs2_i = '0, y_wr_data_i = '0;
   logic [IMM_W-1:0]  imm_i = '0;
   logic              use_imm_i = 1'b0, y_wr_en_i = 1'b0;
   logic              busy_o, done_o;
   logic [DATA_W-1:0] rd_data_o, y_o;

   always #4 clk = ~clk;

   umul_y_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W), .DIGIT_W(DIGIT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
      .imm_i(imm_i), .use_imm_i(use_imm_i), .y_wr_en_i(y_wr_en_i),
      .y_wr_data_i(y_wr_data_i), .busy_o(busy_o), .done_o(done_o),
      .rd_data_o(rd_data_o), .y_o(y_o)
   );

   // behavioural reference
   logic        m_busy = 0, m_done = 0;
   logic [31:0] m_y = 0, m_rd = 0;
   logic [63:0] m_prod = 0;
   int          m_left = 0;
   int          vectors = 0, errors = 0, cycles = 0;
   string       tag = "R1";

   always @(posedge clk) begin
      logic [31:0] b;
      logic        nd;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_y = 0; m_left = 0;
      end else begin
         nd = 0;
         if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               m_busy = 0; nd = 1; m_rd = m_prod[31:0];
            end
         end else if (start_i) begin
            b = use_imm_i ? {{(32-IMM_W){imm_i[IMM_W-1]}}, imm_i} : rs2_i;
            m_prod = {32'h0, rs1_i} * {32'h0, b};
            m_busy = 1; m_left = STEPS;
         end
         if (nd) m_y = m_prod[63:32];
         else if (y_wr_en_i) m_y = y_wr_data_i;
         m_done = nd;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      chk({tag, " R5 busy"}, 64'(busy_o), 64'(m_busy));
      chk({tag, " R6 done"}, 64'(done_o), 64'(m_done));
      chk({tag, " R3 y"}, 64'(y_o), 64'(m_y));
      if (m_done) chk({tag, " R2 low word"}, 64'(rd_data_o), 64'(m_rd));
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic run_mul(input logic [31:0] a, input logic [31:0] b,
                          input logic [12:0] imm, input logic ui, input logic hold_start);
      @(negedge clk);
      rs1_i = a; rs2_i = b; imm_i = imm; use_imm_i = ui; start_i = 1;
      @(negedge clk);
      if (!hold_start) start_i = 0;
      else begin rs1_i = ~a; rs2_i = a ^ b; imm_i = ~imm; use_imm_i = ~ui; end
      while (!m_done) @(negedge clk);
      start_i = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      tag = "R2";
      run_mul(32'd0, 32'd12345, 0, 0, 0);
      run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
      run_mul(32'd1, 32'hDEAD_BEEF, 0, 0, 0);
      run_mul(32'h8000_0000, 32'd2, 0, 0, 0);
      for (int i = 0; i < 20; i++) run_mul($urandom, $urandom, 0, 0, 0);
      tag = "R4";
      run_mul(32'd7, 32'hFFFF_0000, 13'h1FFF, 1, 0);
      run_mul(32'h1234_5678, 32'h5555_5555, 13'h0FFF, 1, 0);
      run_mul(32'hFFFF_FFFF, 32'd9, 13'h1000, 1, 0);
      tag = "R7";
      run_mul(32'hCAFE_0001, 32'h0000_F00D, 0, 0, 1);
      run_mul(32'h0BAD_F00D, 32'h7, 13'h0123, 1, 1);
      tag = "R8";
      @(negedge clk); y_wr_en_i = 1; y_wr_data_i = 32'hA5A5_5A5A;
      @(negedge clk); y_wr_en_i = 0;
      tag = "R10";
      repeat (4) @(negedge clk);
      tag = "R8";
      @(negedge clk); rs1_i = 32'h1111_1111; rs2_i = 32'h10; use_imm_i = 0; start_i = 1;
      @(negedge clk); start_i = 0; y_wr_en_i = 1; y_wr_data_i = 32'h0F0F_0F0F;
      @(negedge clk); y_wr_en_i = 0;
      while (!m_done) @(negedge clk);
      tag = "R9";
      @(negedge clk); rs1_i = 32'hFFFF_0000; rs2_i = 32'hFFFF_0000; start_i = 1;
      @(negedge clk); start_i = 0; y_wr_en_i = 1; y_wr_data_i = 32'h1357_9BDF;
      while (!m_done) @(negedge clk);
      y_wr_en_i = 0;
      tag = "R10";
      repeat (5) @(negedge clk);
      tag = "R1";
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule